// File: doc/BRIEF.md
# Cumulative Row Boundary Address Decoder

This block decides which of a small set of memory rows (chip selects) holds a given physical address. Software programs one boundary byte per row through a byte-wide write port. Each byte is the top of its row in 16 MB steps, counted from address zero, so the boundaries pile up row after row instead of describing each row by a base and a mask. A row begins where the row before it ends, and row 0 begins at zero. A row whose boundary does not rise above its predecessor's has no memory.

A lookup is an address together with a valid strobe. One clock later the block returns four outputs: a one-hot row select with the matching row index, the base address of that row, and the offset of the address within the row. When no populated row covers the address, it raises a miss flag instead. Reset clears every boundary, so all rows are empty and every lookup misses until software programs the boundaries.

Top module: `rbd_row_decoder`

## Requirements
- R1: After reset all boundaries are zero, `rsp_valid` and `rsp_rows` are low, and every lookup made before any boundary write reports a miss.
- R2: When `cfg_we` is high at a clock edge, boundary byte `cfg_sel` (0 to 3) takes `cfg_wdata`. That row's limit becomes the byte times 2^24, i.e. `{cfg_wdata, 24'h0}`. When `cfg_we` is low, the boundaries do not change.
- R3: `rsp_valid` is high for exactly the cycle after each cycle in which `req_valid` is sampled high. The result outputs change only on those edges and hold their value otherwise.
- R4: Row i covers addresses from its base up to, but not including, its limit. The base of row 0 is 0 and the base of row i is the limit of row i-1. `rsp_base` reports the base of the selected row.
- R5: When more than one row qualifies, the lowest-numbered row wins. A row qualifies when it is populated and its limit is strictly above the address.
- R6: A row whose limit is not above its base is empty and is never selected, whatever the address.
- R7: When no row qualifies, including any address at or above the highest limit, `rsp_miss` is 1 and `rsp_rows`, `rsp_idx`, `rsp_base` and `rsp_offset` are all zero.
- R8: On a hit, `rsp_rows` has exactly bit `rsp_idx` set, and `rsp_miss` is 0.
- R9: On a hit, `rsp_offset` equals the request address minus `rsp_base`.
- R10: A lookup sampled at the same edge as a boundary write is decoded with the boundaries held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Boundary write enable |
| cfg_sel | input | 2 | Row whose boundary byte is written |
| cfg_wdata | input | 8 | Boundary value, limit in 16 MB units |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Address to decode |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_rows | output | 4 | One-hot row select |
| rsp_idx | output | 2 | Index of the selected row |
| rsp_miss | output | 1 | No populated row covers the address |
| rsp_base | output | 32 | Base address of the selected row |
| rsp_offset | output | 32 | Address minus row base |

## Verification
The bench probes addresses on both sides of each limit: the last byte below a limit, the first byte at it, and the very top of the 32-bit space with the largest boundary. An off-by-one compare would move these addresses into the wrong row or miss them altogether. It programs equal neighbouring boundaries, so a decoder that forgets to check for empty rows would select a row of zero size. It also programs a falling boundary, so a decoder that picks the highest match or tests only the limit would choose the wrong row. Finally, it writes a boundary in the same cycle as a lookup. A design that sends the new value straight into the decode would answer with the new layout instead of the old one.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int RBD_ADDR_W   = 32;
  localparam int RBD_BND_W    = 8;
  localparam int RBD_NUM_ROWS = 4;
endpackage

// File: rtl/rbd_bound_regs.sv
module rbd_bound_regs #(
  parameter int NUM_ROWS = rbd_pkg::RBD_NUM_ROWS,
  parameter int BND_W    = rbd_pkg::RBD_BND_W,
  parameter int SEL_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [SEL_W-1:0]          sel,
  input  logic [BND_W-1:0]          wdata,
  output logic [NUM_ROWS*BND_W-1:0] bnd_flat
);
  // one byte register per row, cleared to the all-empty layout
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic wr_hit;
    assign wr_hit = we && (sel == SEL_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bnd_flat[r*BND_W +: BND_W] <= '0;
      else if (wr_hit) bnd_flat[r*BND_W +: BND_W] <= wdata;
    end
  end
endmodule

// File: rtl/rbd_row_span.sv
module rbd_row_span #(
  parameter int ADDR_W = rbd_pkg::RBD_ADDR_W,
  parameter int BND_W  = rbd_pkg::RBD_BND_W
) (
  input  logic [BND_W-1:0]  bnd_cur,
  input  logic [BND_W-1:0]  bnd_prev,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base,
  output logic              hit
);
  localparam int UNIT_SHIFT = ADDR_W - BND_W;

  function automatic logic [ADDR_W-1:0] scale_bound(input logic [BND_W-1:0] b);
    return {b, {UNIT_SHIFT{1'b0}}};
  endfunction

  logic [ADDR_W-1:0] lim;
  logic              live;

  assign lim  = scale_bound(bnd_cur);
  assign base = scale_bound(bnd_prev);
  assign live = lim > base;
  assign hit  = live && (addr < lim);
endmodule

// File: rtl/rbd_first_hit.sv
module rbd_first_hit #(
  parameter int NUM_ROWS = rbd_pkg::RBD_NUM_ROWS,
  parameter int SEL_W    = 2
) (
  input  logic [NUM_ROWS-1:0] hits,
  output logic [NUM_ROWS-1:0] first_oh,
  output logic [SEL_W-1:0]    first_idx,
  output logic                any_hit
);
  always_comb begin
    first_oh  = '0;
    first_idx = '0;
    any_hit   = |hits;
    // walk downward so the lowest-numbered hit is the last one kept
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (hits[r]) begin
        first_oh    = '0;
        first_oh[r] = 1'b1;
        first_idx   = SEL_W'(r);
      end
    end
  end
endmodule

// File: rtl/rbd_row_decoder.sv
module rbd_row_decoder #(
  parameter int ADDR_W   = rbd_pkg::RBD_ADDR_W,
  parameter int BND_W    = rbd_pkg::RBD_BND_W,
  parameter int NUM_ROWS = rbd_pkg::RBD_NUM_ROWS,
  localparam int SEL_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [BND_W-1:0]    cfg_wdata,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rsp_valid,
  output logic [NUM_ROWS-1:0] rsp_rows,
  output logic [SEL_W-1:0]    rsp_idx,
  output logic                rsp_miss,
  output logic [ADDR_W-1:0]   rsp_base,
  output logic [ADDR_W-1:0]   rsp_offset
);
  // named internal events, visible to the bound checker
  logic [NUM_ROWS*BND_W-1:0] bnd_flat;
  logic [NUM_ROWS-1:0]       dec_hits;
  logic [NUM_ROWS-1:0]       dec_oh;
  logic [SEL_W-1:0]          dec_idx;
  logic                      dec_any;
  logic [ADDR_W-1:0]         base_sel;
  logic [ADDR_W-1:0]         offset_sel;
  logic [ADDR_W-1:0]         row_base [NUM_ROWS];

  rbd_bound_regs #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .bnd_flat(bnd_flat)
  );

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_span
    logic [BND_W-1:0] prev_b;
    if (r == 0) begin : g_first
      assign prev_b = '0;
    end else begin : g_rest
      assign prev_b = bnd_flat[(r-1)*BND_W +: BND_W];
    end
    rbd_row_span #(.ADDR_W(ADDR_W), .BND_W(BND_W)) u_span (
      .bnd_cur(bnd_flat[r*BND_W +: BND_W]), .bnd_prev(prev_b),
      .addr(req_addr), .base(row_base[r]), .hit(dec_hits[r])
    );
  end

  rbd_first_hit #(.NUM_ROWS(NUM_ROWS), .SEL_W(SEL_W)) u_pick (
    .hits(dec_hits), .first_oh(dec_oh), .first_idx(dec_idx), .any_hit(dec_any)
  );

  always_comb begin
    base_sel = '0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      if (dec_oh[r]) base_sel = base_sel | row_base[r];
    end
  end

  assign offset_sel = dec_any ? (req_addr - base_sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rows   <= '0;
      rsp_idx    <= '0;
      rsp_miss   <= 1'b0;
      rsp_base   <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_rows   <= dec_oh;
        rsp_idx    <= dec_idx;
        rsp_miss   <= !dec_any;
        rsp_base   <= base_sel;
        rsp_offset <= offset_sel;
      end
    end
  end
endmodule

// File: rtl/rbd_row_decoder_chk.sv
module rbd_row_decoder_chk #(
  parameter int ADDR_W   = 32,
  parameter int BND_W    = 8,
  parameter int NUM_ROWS = 4,
  parameter int SEL_W    = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic [ADDR_W-1:0]         req_addr,
  input logic                      rsp_valid,
  input logic [NUM_ROWS-1:0]       rsp_rows,
  input logic [SEL_W-1:0]          rsp_idx,
  input logic                      rsp_miss,
  input logic [ADDR_W-1:0]         rsp_base,
  input logic [ADDR_W-1:0]         rsp_offset,
  input logic [NUM_ROWS*BND_W-1:0] bnd_flat
);
  localparam int SH = ADDR_W - BND_W;

  logic                      armed;
  logic [NUM_ROWS*BND_W-1:0] bnd_q;
  logic [ADDR_W-1:0]         sel_lim;
  logic [ADDR_W-1:0]         prev_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      bnd_q <= '0;
    end else begin
      armed <= 1'b1;
      bnd_q <= bnd_flat;
    end
  end

  always_comb begin
    sel_lim  = {bnd_q[int'(rsp_idx)*BND_W +: BND_W], {SH{1'b0}}};
    prev_lim = '0;
    if (rsp_idx != '0) prev_lim = {bnd_q[(int'(rsp_idx)-1)*BND_W +: BND_W], {SH{1'b0}}};
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rsp_valid == $past(req_valid)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rsp_valid) |-> ($stable(rsp_rows) && $stable(rsp_idx) && $stable(rsp_miss)
                               && $stable(rsp_base) && $stable(rsp_offset)));
  assert_empty_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_valid && (bnd_q == '0)) |-> rsp_miss);
  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss) |-> (rsp_rows == (NUM_ROWS'(1) << rsp_idx)));
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_rows == '0 && rsp_base == '0 && rsp_offset == '0));
  assert_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_valid && !rsp_miss) |-> (rsp_base == prev_lim));
  assert_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_valid && !rsp_miss) |-> (sel_lim > rsp_base));
  assert_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_valid && !rsp_miss) |-> (rsp_offset == $past(req_addr) - rsp_base));
endmodule

bind rbd_row_decoder rbd_row_decoder_chk #(
  .ADDR_W(ADDR_W), .BND_W(BND_W), .NUM_ROWS(NUM_ROWS), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_rows(rsp_rows), .rsp_idx(rsp_idx),
  .rsp_miss(rsp_miss), .rsp_base(rsp_base), .rsp_offset(rsp_offset),
  .bnd_flat(bnd_flat)
);

// File: tb/tb_rbd_row_decoder.sv
`timescale 1ns/1ps
module tb_rbd_row_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_rows;
  logic [1:0]  rsp_idx;
  logic        rsp_miss;
  logic [31:0] rsp_base;
  logic [31:0] rsp_offset;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [3:0]  rows;
    logic [1:0]  idx;
    logic        miss;
    logic [31:0] base;
    logic [31:0] off;
    string       tag;
  } exp_t;

  exp_t      sb[$];
  exp_t      last_seen;
  logic [7:0] bm [4];

  always #2 clk = ~clk;

  rbd_row_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_rows(rsp_rows), .rsp_idx(rsp_idx),
    .rsp_miss(rsp_miss), .rsp_base(rsp_base), .rsp_offset(rsp_offset)
  );

  // reference: walk rows, track previous top, first populated row above addr wins
  function automatic exp_t predict(input logic [31:0] a, input string tag);
    exp_t e;
    logic [32:0] lo;
    logic [32:0] hi;
    bit found;
    e.rows = '0; e.idx = '0; e.miss = 1'b1; e.base = '0; e.off = '0; e.tag = tag;
    lo = '0;
    found = 0;
    for (int r = 0; r < 4; r++) begin
      hi = {1'b0, bm[r]} * 33'd16777216;
      if (!found && hi > lo && {1'b0, a} < hi) begin
        found  = 1;
        e.miss = 1'b0;
        e.idx  = 2'(r);
        e.rows = 4'(1 << r);
        e.base = lo[31:0];
        e.off  = a - lo[31:0];
      end
      lo = hi;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic step_clear();
    @(posedge clk); #1;
    cfg_we = 1'b0; req_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    @(posedge clk); #1;
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    bm[s] = v;
  endtask

  task automatic issue(input logic [31:0] a, input string tag);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    req_valid = 1'b1; req_addr = a;
    sb.push_back(predict(a, tag));
  endtask

  // lookup and boundary write at the same edge: expectation uses old layout (R10)
  task automatic wr_issue(input logic [1:0] s, input logic [7:0] v, input logic [31:0] a);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a;
    sb.push_back(predict(a, "R10"));
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    bm[s] = v;
  endtask

  task automatic idle(input int n);
    step_clear();
    repeat (n - 1) @(posedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3", "response with no pending lookup");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_rows == e.rows && rsp_idx == e.idx && rsp_miss == e.miss
              && rsp_base == e.base && rsp_offset == e.off, e.tag,
              $sformatf("rows=%b idx=%0d miss=%b base=%h off=%h expected rows=%b idx=%0d miss=%b base=%h off=%h",
                        rsp_rows, rsp_idx, rsp_miss, rsp_base, rsp_offset,
                        e.rows, e.idx, e.miss, e.base, e.off));
        last_seen = e;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) bm[r] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(rsp_valid == 1'b0 && rsp_rows == '0, "R1",
          $sformatf("valid=%b rows=%b expected valid=0 rows=0000", rsp_valid, rsp_rows));
    rst_n = 1'b1;
    issue(32'h0000_0000, "R1");
    issue(32'h7000_0000, "R1");
    idle(2);

    // R2 ascending layout 16M, 48M, 112M, 240M
    wr(2'd0, 8'h01); wr(2'd1, 8'h03); wr(2'd2, 8'h07); wr(2'd3, 8'h0F);
    issue(32'h0000_0000, "R4");
    issue(32'h00FF_FFFF, "R4");
    issue(32'h0100_0000, "R9");
    issue(32'h02FF_FFFF, "R9");
    issue(32'h0300_0000, "R8");
    issue(32'h0EFF_FFFF, "R8");
    issue(32'h0F00_0000, "R7");
    issue(32'hFFFF_FFFF, "R7");
    idle(4);
    // R3 hold: outputs unchanged with no lookup
    check(rsp_valid == 1'b0 && rsp_miss == last_seen.miss && rsp_rows == last_seen.rows
          && rsp_base == last_seen.base && rsp_offset == last_seen.off, "R3",
          $sformatf("valid=%b miss=%b base=%h expected valid=0 miss=%b base=%h",
                    rsp_valid, rsp_miss, rsp_base, last_seen.miss, last_seen.base));

    // R2 write enable low: data on the port has no effect
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_sel = 2'd3; cfg_wdata = 8'h00;
    issue(32'h0E00_0000, "R2");
    idle(2);

    // R6 empty rows 1 and 3
    wr(2'd0, 8'h02); wr(2'd1, 8'h02); wr(2'd2, 8'h06); wr(2'd3, 8'h06);
    issue(32'h0180_0000, "R6");
    issue(32'h0200_0000, "R6");
    issue(32'h05FF_FFFF, "R6");
    issue(32'h0600_0000, "R7");
    idle(2);

    // R5 falling boundary: lowest qualifying row wins
    wr(2'd0, 8'h10); wr(2'd1, 8'h08); wr(2'd2, 8'h20); wr(2'd3, 8'h20);
    issue(32'h0C00_0000, "R5");
    issue(32'h1200_0000, "R5");
    issue(32'h1FFF_FFFF, "R5");
    issue(32'h2000_0000, "R7");
    idle(2);

    // top of address space
    wr(2'd3, 8'hFF);
    issue(32'hFEFF_FFFF, "R4");
    issue(32'hFF00_0000, "R7");
    idle(2);

    // R10 same-cycle write and lookup
    wr(2'd0, 8'h01); wr(2'd1, 8'h02); wr(2'd2, 8'h03); wr(2'd3, 8'h04);
    wr_issue(2'd0, 8'h04, 32'h0180_0000);
    issue(32'h0180_0000, "R10");
    idle(3);

    check(sb.size() == 0, "R3",
          $sformatf("pending=%0d expected pending=0", sb.size()));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule